// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control-memory address for a microprogrammed control unit. It holds the current control address and a single saved return address. Each clock it picks the next address from one of four sources: the current address plus one, the branch target carried in the microinstruction, the saved return address, or an address derived from the opcode of the machine instruction. Every machine instruction owns a four-word slot in the lower part of control memory. The dispatch source sends the opcode to the first word of that slot.

Two fields of the present microinstruction steer the choice. The condition code picks one test bit from a constant one and three status inputs. The branch kind names one of four transitions. A jump or a call is taken only when the test bit is 1. A taken call also saves the current address plus one. A return goes to the saved address no matter what the test bit is. A dispatch uses the opcode and nothing else. The four transitions are named Jump, Call, Return and Dispatch. The four address sources are named Step (address plus one), Branch (target field), Return (saved address) and Dispatch (mapped opcode). The control address register is the only sequencing state, and these four sources are its only moves. A synchronous reset sends it to the fetch routine at address 64.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is high at a clock edge, the control address becomes 64 and the saved return address becomes 0.
- R2: The condition code selects the test bit: 2'b00 gives a constant 1, 2'b01 gives `ind_bit`, 2'b10 gives `acc_sign`, and 2'b11 gives `acc_zero`. Status inputs that are not selected have no effect.
- R3: Branch kind 2'b00 (Jump) loads the target field when the test bit is 1. Otherwise it advances to the control address plus one.
- R4: Branch kind 2'b01 (Call) with a test bit of 1 loads the target field and saves the previous control address plus one as the return address.
- R5: Branch kind 2'b01 (Call) with a test bit of 0 advances to the control address plus one and leaves the return address unchanged.
- R6: Branch kind 2'b10 (Return) loads the saved return address whatever the test bit is.
- R7: Branch kind 2'b11 (Dispatch) loads the address {1'b0, opcode[3:0], 2'b00}, so opcode k goes to address 4k.
- R8: The plus-one source wraps from 127 to 0.
- R9: Only one return address is kept. A second taken Call overwrites it, so a Return then goes to the address after the inner call.
- R10: The return address changes only on reset or on a taken Call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition code of the current microinstruction |
| branch_kind | input | 2 | Transition kind: Jump, Call, Return, Dispatch |
| branch_addr | input | 7 | Branch target field of the current microinstruction |
| opcode | input | 4 | Opcode bits of the instruction register (bits 14..11) |
| ind_bit | input | 1 | Indirect flag, instruction bit 15 |
| acc_sign | input | 1 | Accumulator sign, bit 15 |
| acc_zero | input | 1 | Accumulator equals zero |
| ctl_addr | output | 7 | Control address register, drives control memory |
| ret_addr | output | 7 | Saved subroutine return address |

## Verification
The assertions assume that every control and status input is a defined 0 or 1 at each rising edge and stays constant across it. They also assume that reset is held at time zero, so that the values before reset are never judged. The bench changes inputs only on the falling edge, drives every bit of every field with a known value in each step, and holds reset through the first edges. It builds each test bit by setting the selected status input to the wanted value and every other status input to its opposite, so a wrong selection shows up in the next address.

// File: rtl/usq_pkg.sv
package usq_pkg;

    // transition kind carried in the microinstruction
    typedef enum logic [1:0] {
        BK_JUMP     = 2'b00,
        BK_CALL     = 2'b01,
        BK_RETURN   = 2'b10,
        BK_DISPATCH = 2'b11
    } usq_kind_e;

    // condition code choosing the test bit
    typedef enum logic [1:0] {
        CS_ALWAYS = 2'b00,
        CS_IND    = 2'b01,
        CS_SIGN   = 2'b10,
        CS_ZERO   = 2'b11
    } usq_cond_e;

    // next-address source, encoded as {s1, s0}
    typedef enum logic [1:0] {
        SRC_STEP     = 2'b00,
        SRC_BRANCH   = 2'b01,
        SRC_RETURN   = 2'b10,
        SRC_DISPATCH = 2'b11
    } usq_src_e;

endpackage

// File: rtl/usq_cond_mux.sv
module usq_cond_mux
    import usq_pkg::*;
(
    input  usq_cond_e cond_sel,
    input  logic      ind_bit,
    input  logic      acc_sign,
    input  logic      acc_zero,
    output logic      test_bit
);

    always_comb begin
        unique case (cond_sel)
            CS_ALWAYS: test_bit = 1'b1;
            CS_IND:    test_bit = ind_bit;
            CS_SIGN:   test_bit = acc_sign;
            CS_ZERO:   test_bit = acc_zero;
            default:   test_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/usq_src_decode.sv
module usq_src_decode
    import usq_pkg::*;
(
    input  usq_kind_e branch_kind,
    input  logic      test_bit,
    output usq_src_e  src_sel,
    output logic      ret_load
);

    logic i1, i0, s1, s0;

    always_comb begin
        i1       = branch_kind[1];
        i0       = branch_kind[0];
        // closed-form select: s1 = i1, s0 = i1*i0 + i1'*t
        s1       = i1;
        s0       = (i1 & i0) | (~i1 & test_bit);
        src_sel  = usq_src_e'({s1, s0});
        // save the return address only on a taken call
        ret_load = ~i1 & i0 & test_bit;
    end

endmodule

// File: rtl/usq_addr_mux.sv
module usq_addr_mux
    import usq_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int OPC_W    = 4,
    parameter int SLOT_LOG = 2
) (
    input  usq_src_e           src_sel,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [ADDR_W-1:0]  branch_addr,
    input  logic [ADDR_W-1:0]  saved_addr,
    input  logic [OPC_W-1:0]   opcode,
    output logic [ADDR_W-1:0]  step_addr,
    output logic [ADDR_W-1:0]  next_addr
);

    localparam int MAP_W = OPC_W + SLOT_LOG;

    logic [ADDR_W-1:0] map_addr;
    logic [MAP_W-1:0]  slot_base;

    assign slot_base = {opcode, {SLOT_LOG{1'b0}}};

    generate
        if (MAP_W == ADDR_W) begin : g_map_full
            assign map_addr = slot_base;
        end else begin : g_map_pad
            assign map_addr = {{(ADDR_W-MAP_W){1'b0}}, slot_base};
        end
    endgenerate

    // natural truncation gives the wrap from the top address to zero
    assign step_addr = cur_addr + ADDR_W'(1);

    always_comb begin
        unique case (src_sel)
            SRC_STEP:     next_addr = step_addr;
            SRC_BRANCH:   next_addr = branch_addr;
            SRC_RETURN:   next_addr = saved_addr;
            SRC_DISPATCH: next_addr = map_addr;
            default:      next_addr = step_addr;
        endcase
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import usq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int OPC_W      = 4,
    parameter int SLOT_LOG   = 2,
    parameter int FETCH_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cond_sel,
    input  logic [1:0]        branch_kind,
    input  logic [ADDR_W-1:0] branch_addr,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              ind_bit,
    input  logic              acc_sign,
    input  logic              acc_zero,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic [ADDR_W-1:0] ret_addr
);

    localparam logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(FETCH_ADDR);

    logic [ADDR_W-1:0] car_q, car_d;
    logic [ADDR_W-1:0] sbr_q, sbr_d;
    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              test_bit;
    logic              ret_load;
    usq_src_e          src_sel;

    usq_cond_mux u_cond (
        .cond_sel (usq_cond_e'(cond_sel)),
        .ind_bit  (ind_bit),
        .acc_sign (acc_sign),
        .acc_zero (acc_zero),
        .test_bit (test_bit)
    );

    usq_src_decode u_dec (
        .branch_kind (usq_kind_e'(branch_kind)),
        .test_bit    (test_bit),
        .src_sel     (src_sel),
        .ret_load    (ret_load)
    );

    usq_addr_mux #(
        .ADDR_W   (ADDR_W),
        .OPC_W    (OPC_W),
        .SLOT_LOG (SLOT_LOG)
    ) u_mux (
        .src_sel     (src_sel),
        .cur_addr    (car_q),
        .branch_addr (branch_addr),
        .saved_addr  (sbr_q),
        .opcode      (opcode),
        .step_addr   (step_addr),
        .next_addr   (next_addr)
    );

    // next-state logic for both registers
    always_comb begin
        car_d = next_addr;
        sbr_d = ret_load ? step_addr : sbr_q;
    end

    // state registers
    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= RESET_ADDR;
            sbr_q <= '0;
        end else begin
            car_q <= car_d;
            sbr_q <= sbr_d;
        end
    end

    // outputs
    always_comb begin
        ctl_addr = car_q;
        ret_addr = sbr_q;
    end

endmodule

// File: rtl/usq_chk.sv
module usq_chk #(
    parameter int ADDR_W     = 7,
    parameter int OPC_W      = 4,
    parameter int SLOT_LOG   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cond_sel,
    input logic [1:0]        branch_kind,
    input logic [ADDR_W-1:0] branch_addr,
    input logic [OPC_W-1:0]  opcode,
    input logic              ind_bit,
    input logic              acc_sign,
    input logic              acc_zero,
    input logic [ADDR_W-1:0] ctl_addr,
    input logic [ADDR_W-1:0] ret_addr
);

    logic t_chk;
    always_comb begin
        case (cond_sel)
            2'b01:   t_chk = ind_bit;
            2'b10:   t_chk = acc_sign;
            2'b11:   t_chk = acc_zero;
            default: t_chk = 1'b1;
        endcase
    end

    // R3
    jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_kind == 2'b00 && t_chk) |=> ctl_addr == $past(branch_addr));

    // R4
    call_save_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_kind == 2'b01 && t_chk) |=>
            (ret_addr == ADDR_W'($past(ctl_addr) + ADDR_W'(1)) && ctl_addr == $past(branch_addr)));

    // R5
    call_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_kind == 2'b01 && !t_chk) |=>
            ($stable(ret_addr) && ctl_addr == ADDR_W'($past(ctl_addr) + ADDR_W'(1))));

    // R6
    return_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_kind == 2'b10) |=> ctl_addr == $past(ret_addr));

    // R7
    dispatch_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_kind == 2'b11) |=> ctl_addr == ADDR_W'({$past(opcode), {SLOT_LOG{1'b0}}}));

    // R10
    ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_kind != 2'b01) |=> $stable(ret_addr));

endmodule

bind useq_sequencer usq_chk #(
    .ADDR_W   (ADDR_W),
    .OPC_W    (OPC_W),
    .SLOT_LOG (SLOT_LOG)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cond_sel    (cond_sel),
    .branch_kind (branch_kind),
    .branch_addr (branch_addr),
    .opcode      (opcode),
    .ind_bit     (ind_bit),
    .acc_sign    (acc_sign),
    .acc_zero    (acc_zero),
    .ctl_addr    (ctl_addr),
    .ret_addr    (ret_addr)
);

// File: tb/useq_sequencer_test.sv
`timescale 1ns/1ps
module useq_sequencer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cond_sel = 2'b00;
    logic [1:0] branch_kind = 2'b00;
    logic [6:0] branch_addr = 7'd0;
    logic [3:0] opcode = 4'd0;
    logic       ind_bit = 1'b0;
    logic       acc_sign = 1'b0;
    logic       acc_zero = 1'b0;
    logic [6:0] ctl_addr;
    logic [6:0] ret_addr;

    int n_cmp = 0;
    int n_bad = 0;
    logic [6:0] exp_car = 7'd64;
    logic [6:0] exp_sbr = 7'd0;

    always #2.5 clk = ~clk;

    useq_sequencer uut (
        .clk         (clk),
        .rst         (rst),
        .cond_sel    (cond_sel),
        .branch_kind (branch_kind),
        .branch_addr (branch_addr),
        .opcode      (opcode),
        .ind_bit     (ind_bit),
        .acc_sign    (acc_sign),
        .acc_zero    (acc_zero),
        .ctl_addr    (ctl_addr),
        .ret_addr    (ret_addr)
    );

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // one microinstruction: drive on the falling edge, compare after the rising edge
    task automatic step(input logic [1:0] cd, input logic [1:0] br, input logic [6:0] ad,
                        input logic [3:0] op, input logic ib, input logic sg, input logic zr,
                        input string tag);
        logic       t;
        logic [6:0] ncar;
        logic [6:0] nsbr;
        @(negedge clk);
        cond_sel = cd; branch_kind = br; branch_addr = ad; opcode = op;
        ind_bit = ib; acc_sign = sg; acc_zero = zr;
        t = (cd == 2'b00) ? 1'b1 : (cd == 2'b01) ? ib : (cd == 2'b10) ? sg : zr;
        ncar = exp_car + 7'd1;
        nsbr = exp_sbr;
        case (br)
            2'b00: if (t) ncar = ad;
            2'b01: if (t) begin ncar = ad; nsbr = exp_car + 7'd1; end
            2'b10: ncar = exp_sbr;
            default: ncar = {1'b0, op, 2'b00};
        endcase
        @(posedge clk); #1;
        exp_car = ncar;
        exp_sbr = nsbr;
        chk({tag, " addr"}, ctl_addr, exp_car);
        chk({tag, " ret"}, ret_addr, exp_sbr);
    endtask

    task automatic goto_addr(input logic [6:0] a);
        step(2'b00, 2'b00, a, 4'd0, 1'b0, 1'b0, 1'b0, "R3 setup jump");
    endtask

    // R1: reset state
    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        exp_car = 7'd64; exp_sbr = 7'd0;
        chk("R1 reset addr", ctl_addr, 7'd64);
        chk("R1 reset ret", ret_addr, 7'd0);
        @(negedge clk); rst = 1'b0;
    endtask

    // R2..R7, R10: every condition code and branch kind for both test values
    task automatic t_all_combos;
        for (int cd = 0; cd < 4; cd++) begin
            for (int br = 0; br < 4; br++) begin
                for (int tv = 0; tv < 2; tv++) begin
                    logic ib, sg, zr;
                    string tag;
                    ib = ~tv[0]; sg = ~tv[0]; zr = ~tv[0];
                    if (cd == 1) ib = tv[0];
                    if (cd == 2) sg = tv[0];
                    if (cd == 3) zr = tv[0];
                    goto_addr(7'd20 + 7'(cd * 8 + br * 2 + tv));
                    case (br)
                        0: tag = "R2 R3 jump";
                        1: tag = "R2 R4 R5 call";
                        2: tag = "R6 R10 return";
                        default: tag = "R7 R10 dispatch";
                    endcase
                    step(2'(cd), 2'(br), 7'd90 + 7'(cd), 4'(5 + br), ib, sg, zr,
                         $sformatf("%s cd=%0d t=%0d", tag, cd, tv));
                end
            end
        end
    endtask

    // R5: not-taken call keeps a known, non-zero return address
    task automatic t_call_skip;
        step(2'b00, 2'b01, 7'd33, 4'd0, 1'b0, 1'b0, 1'b0, "R4 prime call");
        step(2'b11, 2'b01, 7'd77, 4'd0, 1'b1, 1'b1, 1'b0, "R5 call skipped on zero");
        step(2'b01, 2'b01, 7'd77, 4'd0, 1'b0, 1'b1, 1'b1, "R5 call skipped on ind");
    endtask

    // R7: every opcode lands at four times its value
    task automatic t_dispatch;
        for (int k = 0; k < 16; k++) begin
            step(2'b00, 2'b11, 7'd127, 4'(k), 1'b1, 1'b1, 1'b1, "R7 dispatch slot");
        end
    endtask

    // R8: plus-one wraps at the top
    task automatic t_wrap;
        goto_addr(7'd127);
        step(2'b01, 2'b00, 7'd5, 4'd0, 1'b0, 1'b1, 1'b1, "R8 wrap via jump skip");
        goto_addr(7'd127);
        step(2'b10, 2'b01, 7'd5, 4'd0, 1'b1, 1'b0, 1'b1, "R8 wrap via call skip");
        goto_addr(7'd126);
        step(2'b00, 2'b01, 7'd40, 4'd0, 1'b0, 1'b0, 1'b0, "R4 R8 call at 126");
        goto_addr(7'd127);
        step(2'b00, 2'b01, 7'd41, 4'd0, 1'b0, 1'b0, 1'b0, "R4 R8 saved wraps");
    endtask

    // R9: second call overwrites the single return slot
    task automatic t_nested;
        goto_addr(7'd10);
        step(2'b00, 2'b01, 7'd30, 4'd0, 1'b0, 1'b0, 1'b0, "R9 outer call");
        step(2'b11, 2'b01, 7'd50, 4'd0, 1'b0, 1'b0, 1'b1, "R9 inner call");
        step(2'b00, 2'b10, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0, "R9 return to inner");
        step(2'b00, 2'b10, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0, "R9 second return");
    endtask

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 power-up addr", ctl_addr, 7'd64);
        chk("R1 power-up ret", ret_addr, 7'd0);
        @(negedge clk); rst = 1'b0;
        t_all_combos();
        t_call_skip();
        t_dispatch();
        t_wrap();
        t_nested();
        t_reset();
        step(2'b00, 2'b00, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0, "R1 R3 after reset");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule